// File: doc/BRIEF.md
# Isolation Switch Sequencing Controller

This controller commands the latching input isolation switches of two redundant power converters, called channel A and channel B, plus one shared bypass switch. It takes its cue from a polarity indication of the input bus. A positive bus means the switches must all be driven open. A negative bus marks the safe low-voltage condition in which the input isolation switches may be closed. Switches are only ever operated during one of these two qualified conditions. They are never switched while power flows at high voltage.

After both isolation switches have been closed, the controller waits a settling interval. It then samples a per-channel fault detector located at each converter input. A channel that shows a fault has its isolation switch driven open again on its own. The healthy channel stays connected. Two health flags, one per channel, report the outcome to a supervisory controller. A later positive-bus condition clears both flags.

Because the switches latch mechanically, each switch is driven by separate set (close) and reset (open) pulse lines. Each pulse is high for a fixed, parameterised number of clocks.

Top module: `iso_seq_ctrl`

## Requirements
- R1: The polarity input passes through a two-flop synchronizer. A new level takes effect only after it has held for STABLE_CYC (default 16) consecutive clocks. A shorter excursion produces no pulse on any switch output.
- R2: When a negative bus becomes qualified, the controller issues exactly one close pulse on each of s1a_set_o and s1b_set_o, starting in the same cycle. It issues no pulse on s2_rst_o.
- R3: When a positive bus becomes qualified after a negative one, the controller issues exactly one open pulse on each of s1a_rst_o, s1b_rst_o and s2_rst_o, all starting together. Both health flags are 0 from the first cycle of those pulses.
- R4: Every pulse on any switch output is high for exactly PULSE_LEN (default 8) consecutive clocks. The set and reset lines of the same switch are never high together.
- R5: The fault inputs (level 1 = fault) are sampled once, SETTLE_CYC (default 256) clocks after the close pulses end. A fault that disappears before that sample is ignored.
- R6: A channel that is faulted at the sample receives exactly one open pulse on its own isolation switch reset line. A healthy channel receives none.
- R7: a_ok_o and b_ok_o are 0 after reset and stay 0 throughout the settling interval. After the sample, each flag equals the inverse of its channel's sampled fault level. The flags then hold regardless of later fault input changes until a positive bus is qualified.
- R8: If the bus returns to positive during the settling interval, the fault sample is skipped. Both flags stay 0, and one open pulse is issued on all three switches.
- R9: During and after reset, all five switch pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_neg_i | input | 1 | Bus polarity, 1 = negative (low-voltage, safe to close), 0 = positive |
| fault_a_i | input | 1 | Channel A converter-input fault detector, 1 = fault |
| fault_b_i | input | 1 | Channel B converter-input fault detector, 1 = fault |
| s1a_set_o | output | 1 | Close pulse for channel A isolation switch |
| s1b_set_o | output | 1 | Close pulse for channel B isolation switch |
| s1a_rst_o | output | 1 | Open pulse for channel A isolation switch |
| s1b_rst_o | output | 1 | Open pulse for channel B isolation switch |
| s2_rst_o | output | 1 | Open pulse for the shared bypass switch |
| a_ok_o | output | 1 | Channel A healthy after the fault check |
| b_ok_o | output | 1 | Channel B healthy after the fault check |

## Verification
The close-and-check sequence is run under four fault patterns:
- no fault on either channel;
- a fault on A only;
- faults on both channels;
- a fault on A that clears before the sample.

These patterns separate a correct per-channel trip from swapped channels, from a trip applied to both channels, and from sampling too early. A short polarity excursion confirms that the qualifier blocks premature action. A return to positive mid-settle confirms that the check is aborted and all switches are opened. After each sequence, the counts of close and open pulses per switch are compared with the expected values. Every pulse width is also measured.

// File: rtl/iso_seq_pkg.sv
package iso_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLOSE,
        ST_SETTLE,
        ST_TRIP,
        ST_OPEN
    } seq_state_e;

    // One bit per switch pulse line; order fixes the pulse-generator index.
    typedef struct packed {
        logic s1a_set;
        logic s1b_set;
        logic s1a_rst;
        logic s1b_rst;
        logic s2_rst;
    } sw_cmd_t;

    localparam int NUM_SW = $bits(sw_cmd_t);

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/iso_sync2.sv
module iso_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q_o    <= '0;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/iso_level_filter.sv
module iso_level_filter #(
    parameter int STABLE_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic level_o
);
    localparam int CW = $clog2(STABLE_CYC + 1);

    logic          sync_s;
    logic [CW-1:0] run_q;

    iso_sync2 #(.W(1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_i),
        .q_o (sync_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            level_o <= 1'b0;
            run_q   <= '0;
        end else if (sync_s != level_o) begin
            if (run_q == CW'(STABLE_CYC - 1)) begin
                level_o <= sync_s;
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end
endmodule

// File: rtl/iso_pulse_gen.sv
module iso_pulse_gen #(
    parameter int PULSE_LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic fire_i,
    output logic pulse_o
);
    localparam int CW = $clog2(PULSE_LEN + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_o <= 1'b0;
            left_q  <= '0;
        end else if (fire_i) begin
            pulse_o <= 1'b1;
            left_q  <= CW'(PULSE_LEN - 1);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end else begin
            pulse_o <= 1'b0;
        end
    end
endmodule

// File: rtl/iso_seq_fsm.sv
module iso_seq_fsm
    import iso_seq_pkg::*;
#(
    parameter int PULSE_LEN  = 8,
    parameter int SETTLE_CYC = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_neg_q,
    input  logic [1:0] fault_q,   // bit 0 channel A, bit 1 channel B
    output sw_cmd_t    fire_o,
    output logic [1:0] ok_o
);
    localparam int TW = $clog2(max2(PULSE_LEN, SETTLE_CYC) + 1);
    localparam logic [TW-1:0] T_PULSE  = TW'(PULSE_LEN - 1);
    localparam logic [TW-1:0] T_SETTLE = TW'(SETTLE_CYC - 1);

    seq_state_e    state_q, state_d;
    logic [TW-1:0] tmr_q, tmr_d;
    logic          closed_q, closed_d;
    logic [1:0]    ok_d;

    always_comb begin
        state_d  = state_q;
        tmr_d    = (tmr_q != '0) ? tmr_q - 1'b1 : tmr_q;
        closed_d = closed_q;
        ok_d     = ok_o;
        fire_o   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (bus_neg_q && !closed_q) begin
                    fire_o.s1a_set = 1'b1;
                    fire_o.s1b_set = 1'b1;
                    closed_d       = 1'b1;
                    tmr_d          = T_PULSE;
                    state_d        = ST_CLOSE;
                end else if (!bus_neg_q && closed_q) begin
                    fire_o.s1a_rst = 1'b1;
                    fire_o.s1b_rst = 1'b1;
                    fire_o.s2_rst  = 1'b1;
                    closed_d       = 1'b0;
                    ok_d           = 2'b00;
                    tmr_d          = T_PULSE;
                    state_d        = ST_OPEN;
                end
            end
            ST_CLOSE: begin
                if (tmr_q == '0) begin
                    tmr_d   = T_SETTLE;
                    state_d = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (!bus_neg_q) begin
                    fire_o.s1a_rst = 1'b1;
                    fire_o.s1b_rst = 1'b1;
                    fire_o.s2_rst  = 1'b1;
                    closed_d       = 1'b0;
                    ok_d           = 2'b00;
                    tmr_d          = T_PULSE;
                    state_d        = ST_OPEN;
                end else if (tmr_q == '0) begin
                    fire_o.s1a_rst = fault_q[0];
                    fire_o.s1b_rst = fault_q[1];
                    ok_d           = ~fault_q;
                    tmr_d          = T_PULSE;
                    state_d        = ST_TRIP;
                end
            end
            ST_TRIP, ST_OPEN: begin
                if (tmr_q == '0) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            tmr_q    <= '0;
            closed_q <= 1'b0;
            ok_o     <= 2'b00;
        end else begin
            state_q  <= state_d;
            tmr_q    <= tmr_d;
            closed_q <= closed_d;
            ok_o     <= ok_d;
        end
    end
endmodule

// File: rtl/iso_seq_ctrl.sv
module iso_seq_ctrl
    import iso_seq_pkg::*;
#(
    parameter int PULSE_LEN  = 8,
    parameter int SETTLE_CYC = 256,
    parameter int STABLE_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_neg_i,
    input  logic fault_a_i,
    input  logic fault_b_i,
    output logic s1a_set_o,
    output logic s1b_set_o,
    output logic s1a_rst_o,
    output logic s1b_rst_o,
    output logic s2_rst_o,
    output logic a_ok_o,
    output logic b_ok_o
);
    logic              bus_neg_q;
    logic [1:0]        fault_q;
    logic [1:0]        ok_s;
    sw_cmd_t           fire_s;
    sw_cmd_t           pulse_s;
    logic [NUM_SW-1:0] fire_vec;
    logic [NUM_SW-1:0] pulse_vec;

    iso_level_filter #(.STABLE_CYC(STABLE_CYC)) u_pol (
        .clk     (clk),
        .rst     (rst),
        .raw_i   (bus_neg_i),
        .level_o (bus_neg_q)
    );

    iso_sync2 #(.W(2)) u_fsync (
        .clk (clk),
        .rst (rst),
        .d_i ({fault_b_i, fault_a_i}),
        .q_o (fault_q)
    );

    iso_seq_fsm #(
        .PULSE_LEN  (PULSE_LEN),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .bus_neg_q (bus_neg_q),
        .fault_q   (fault_q),
        .fire_o    (fire_s),
        .ok_o      (ok_s)
    );

    assign fire_vec = fire_s;

    for (genvar i = 0; i < NUM_SW; i++) begin : g_pulse
        iso_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pg (
            .clk     (clk),
            .rst     (rst),
            .fire_i  (fire_vec[i]),
            .pulse_o (pulse_vec[i])
        );
    end

    assign pulse_s   = sw_cmd_t'(pulse_vec);
    assign s1a_set_o = pulse_s.s1a_set;
    assign s1b_set_o = pulse_s.s1b_set;
    assign s1a_rst_o = pulse_s.s1a_rst;
    assign s1b_rst_o = pulse_s.s1b_rst;
    assign s2_rst_o  = pulse_s.s2_rst;
    assign a_ok_o    = ok_s[0];
    assign b_ok_o    = ok_s[1];
endmodule

// File: rtl/iso_seq_chk.sv
module iso_seq_chk (
    input logic clk,
    input logic rst,
    input logic bus_neg_q,
    input logic s1a_set,
    input logic s1b_set,
    input logic s1a_rst,
    input logic s1b_rst,
    input logic s2_rst,
    input logic a_ok,
    input logic b_ok
);
    // R9: outputs low while in reset
    p_quiet_in_reset_r9: assert property (@(posedge clk)
        rst |=> !(s1a_set || s1b_set || s1a_rst || s1b_rst || s2_rst));

    // R4: set and reset of one switch never together
    p_excl_a_r4: assert property (@(posedge clk) disable iff (rst)
        !(s1a_set && s1a_rst));
    p_excl_b_r4: assert property (@(posedge clk) disable iff (rst)
        !(s1b_set && s1b_rst));

    // R4: a pulse lasts more than one cycle
    p_width_a_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(s1a_set) |=> s1a_set);

    // R1: close pulses only start once negative is qualified
    p_close_needs_neg_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(s1a_set) |-> $past(bus_neg_q));

    // R2: both close pulses start together, bypass untouched
    p_close_pair_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(s1a_set) |-> ($rose(s1b_set) && !s2_rst));

    // R3: bypass open comes with both isolation opens and cleared flags
    p_open_all_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(s2_rst) |-> (s1a_rst && s1b_rst && !a_ok && !b_ok));

    // R6: a tripped channel is never reported healthy
    p_trip_a_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(s1a_rst) && !s2_rst) |-> !a_ok);
    p_trip_b_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(s1b_rst) && !s2_rst) |-> !b_ok);

    // R7: a flag rises only when its channel is not being opened
    p_ok_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(a_ok) |-> (!s1a_rst && !s1a_set));
endmodule

bind iso_seq_ctrl iso_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_neg_q (bus_neg_q),
    .s1a_set   (s1a_set_o),
    .s1b_set   (s1b_set_o),
    .s1a_rst   (s1a_rst_o),
    .s1b_rst   (s1b_rst_o),
    .s2_rst    (s2_rst_o),
    .a_ok      (a_ok_o),
    .b_ok      (b_ok_o)
);

// File: tb/iso_seq_ctrl_tb.sv
`timescale 1ns/1ps
module iso_seq_ctrl_tb;
    localparam int PULSE_LEN = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_neg = 1'b0, fault_a = 1'b0, fault_b = 1'b0;
    logic s1a_set, s1b_set, s1a_rst, s1b_rst, s2_rst, a_ok, b_ok;

    int n_checks = 0, n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    iso_seq_ctrl u_dut (
        .clk (clk), .rst (rst), .bus_neg_i (bus_neg),
        .fault_a_i (fault_a), .fault_b_i (fault_b),
        .s1a_set_o (s1a_set), .s1b_set_o (s1b_set),
        .s1a_rst_o (s1a_rst), .s1b_rst_o (s1b_rst), .s2_rst_o (s2_rst),
        .a_ok_o (a_ok), .b_ok_o (b_ok)
    );

    // Pulse monitor: index 0 s1a_set, 1 s1b_set, 2 s1a_rst, 3 s1b_rst, 4 s2_rst
    int   pcount [5];
    int   prun   [5];
    logic prev   [5];
    int   width_err = 0, overlap_err = 0;
    logic [4:0] outs;
    assign outs = {s2_rst, s1b_rst, s1a_rst, s1b_set, s1a_set};

    initial for (int i = 0; i < 5; i++) begin
        pcount[i] = 0; prun[i] = 0; prev[i] = 1'b0;
    end

    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < 5; i++) begin
                if (outs[i]) begin
                    if (!prev[i]) pcount[i]++;
                    prun[i]++;
                end else if (prev[i]) begin
                    if (prun[i] != PULSE_LEN) width_err++;
                    prun[i] = 0;
                end
                prev[i] = outs[i];
            end
            if ((s1a_set && s1a_rst) || (s1b_set && s1b_rst)) overlap_err++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    int base [5];
    task automatic snap();
        for (int i = 0; i < 5; i++) base[i] = pcount[i];
    endtask
    function automatic int delta(input int i);
        return pcount[i] - base[i];
    endfunction

    task automatic go_positive(input string req);
        snap();
        bus_neg = 1'b0;
        cycles(60);
        chk(req, "s1a open pulses", delta(2), 1);
        chk(req, "s1b open pulses", delta(3), 1);
        chk(req, "s2 open pulses", delta(4), 1);
        chk(req, "close pulses", delta(0) + delta(1), 0);
        chk(req, "ok flags", {a_ok, b_ok}, 0);
        fault_a = 1'b0; fault_b = 1'b0;
    endtask

    task automatic close_and_check(input bit fa, input bit fb, input string tag);
        snap();
        fault_a = fa; fault_b = fb;
        bus_neg = 1'b1;
        cycles(150);
        chk("R7", {tag, " flags low while settling"}, {a_ok, b_ok}, 0);
        cycles(250);
        chk("R2", {tag, " s1a close pulses"}, delta(0), 1);
        chk("R2", {tag, " s1b close pulses"}, delta(1), 1);
        chk("R2", {tag, " s2 untouched"}, delta(4), 0);
        chk("R6", {tag, " s1a trips"}, delta(2), int'(fa));
        chk("R6", {tag, " s1b trips"}, delta(3), int'(fb));
        chk("R7", {tag, " a_ok"}, a_ok, int'(!fa));
        chk("R7", {tag, " b_ok"}, b_ok, int'(!fb));
    endtask

    task automatic t_reset();
        cycles(3);
        chk("R9", "pulse outputs in reset", outs, 0);
        chk("R7", "ok flags in reset", {a_ok, b_ok}, 0);
        rst = 1'b0;
        cycles(5);
        chk("R9", "pulse outputs after reset", outs, 0);
    endtask

    task automatic t_glitch();
        snap();
        bus_neg = 1'b1;
        cycles(10);
        bus_neg = 1'b0;
        cycles(60);
        for (int i = 0; i < 5; i++) chk("R1", "no pulse on glitch", delta(i), 0);
    endtask

    task automatic t_no_fault();
        close_and_check(1'b0, 1'b0, "clean");
        snap();
        fault_a = 1'b1; fault_b = 1'b1;
        cycles(50);
        chk("R7", "flags held after late fault", {a_ok, b_ok}, 2'b11);
        chk("R7", "no trip on late fault", delta(2) + delta(3), 0);
        go_positive("R3");
    endtask

    task automatic t_fault_a();
        close_and_check(1'b1, 1'b0, "faultA");
        go_positive("R3");
    endtask

    task automatic t_fault_both();
        close_and_check(1'b1, 1'b1, "faultAB");
        go_positive("R3");
    endtask

    task automatic t_transient();
        snap();
        fault_a = 1'b1;
        bus_neg = 1'b1;
        cycles(150);
        fault_a = 1'b0;
        cycles(250);
        chk("R5", "transient fault ignored a_ok", a_ok, 1);
        chk("R5", "transient fault no trip", delta(2), 0);
        go_positive("R3");
    endtask

    task automatic t_abort();
        snap();
        bus_neg = 1'b1;
        cycles(100);
        bus_neg = 1'b0;
        cycles(80);
        chk("R8", "close pulses before abort", delta(0) + delta(1), 2);
        chk("R8", "s1a opened once", delta(2), 1);
        chk("R8", "s1b opened once", delta(3), 1);
        chk("R8", "s2 opened once", delta(4), 1);
        cycles(300);
        chk("R8", "no later trips", delta(2) + delta(3), 2);
        chk("R8", "flags stay low", {a_ok, b_ok}, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_glitch();
        t_no_fault();
        t_fault_a();
        t_fault_both();
        t_transient();
        t_abort();
        chk("R4", "pulse width errors", width_err, 0);
        chk("R4", "set/reset overlap", overlap_err, 0);
        finish_run();
    end

    initial begin
        #1500000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule